// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the load/store stage of a 32-bit core and a 32-bit data memory port. For a store it steers the source operand onto the byte lanes named by the low address bits and raises one write strobe per lane. For a load it picks the addressed byte, halfword or word out of the word the memory returns and widens it to 32 bits, filling with zeros or with copies of the top bit as each access asks.

A static configuration pin picks little-endian or big-endian lane numbering; it is not part of the operation encoding. Accesses whose address does not suit their size are flagged in the request cycle and never reach the memory as writes. The widened load value is registered and appears, with a one-cycle valid strobe, on the clock edge after the memory presents its data.

Top module: `lsu_lane_align`

## Requirements
- R1: While reset is asserted and right after it is released, `ld_valid_o` is 0 and `ld_data_o` is 0.
- R2: A byte store (`req_size_i` = 2'b00) drives strobe pattern 4'b0001 shifted left by the lane, where the lane is `addr[1:0]` in little-endian mode and 3 minus `addr[1:0]` in big-endian mode; `mem_wdata_o` carries `wr_data_i[7:0]` copied into all four lanes.
- R3: A halfword store (2'b01) drives 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1 in little-endian mode, the two patterns swapped in big-endian mode; `mem_wdata_o` carries `wr_data_i[15:0]` in both halves.
- R4: A word store (2'b10, and 2'b11 which behaves as a word) drives strobes 4'b1111 and passes `wr_data_i` unchanged, in either mode.
- R5: `misaligned_o` is 1 in the request cycle when a halfword address has bit 0 set or a word address has either low bit set; `mem_wen_o` and `mem_be_o` are then 0. Byte accesses are never misaligned.
- R6: A byte load returns the byte from the same lane rule as R2, with bits 31:8 zero when `req_signed_i` was 0.
- R7: With `req_signed_i` set, a byte or halfword load fills the upper bits with bit 7 or bit 15 of the selected data.
- R8: A halfword load returns bits 15:0 of the word when the lane rule of R3 selects the low half and bits 31:16 when it selects the high half.
- R9: A word load returns the memory word unchanged whatever the signedness.
- R10: `ld_valid_o` is high exactly in the cycle after each cycle with `rsp_valid_i` high, and `ld_data_o` holds its value while no new data arrives.
- R11: A load request never raises `mem_wen_o`, and a misaligned load does not replace the size, offset and signedness of the last aligned load, which decode the next returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian_i | input | 1 | Static lane ordering: 1 big-endian, 0 little-endian |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 store, 0 load |
| req_size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_signed_i | input | 1 | Load widening: 1 sign, 0 zero |
| wr_data_i | input | DATA_W | Store operand, right-aligned |
| mem_wen_o | output | 1 | Memory write enable |
| mem_be_o | output | DATA_W/8 | Per-lane write strobes |
| mem_wdata_o | output | DATA_W | Lane-steered store data |
| misaligned_o | output | 1 | Request address not aligned to its size |
| rsp_valid_i | input | 1 | Memory load data present |
| rsp_data_i | input | DATA_W | Word returned by memory |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | DATA_W | Extracted and widened load result |

## Verification
The only state inside is the captured context of the last aligned load and the registered result. A corrupted context shows at the ports on the very next returned word as a byte from the wrong lane, a wrong half or a wrong fill pattern, so each load test decodes a word with distinct bytes in every lane and a set top bit. Faults in the store steering or the misalignment decode are combinational and appear in the request cycle itself, which is why every offset is swept in both lane orderings.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/align_check.sv
module align_check
    import lane_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  xfer_size_e       size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = |off;
        endcase
    end
endmodule

// File: rtl/store_lane_packer.sv
module store_lane_packer
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     big_endian,
    input  xfer_size_e               size,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [DATA_W-1:0]        src,
    output logic [DATA_W/8-1:0]      lane_en,
    output logic [DATA_W-1:0]        lane_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;
    logic [OFF_W-1:0]  byte_lane;
    logic [OFF_W-1:0]  half_lane;

    for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
        assign byte_rep[8*g +: 8] = src[7:0];
    end
    for (genvar g = 0; g < LANES / 2; g++) begin : g_half_rep
        assign half_rep[16*g +: 16] = src[15:0];
    end

    always_comb begin
        byte_lane = big_endian ? ~off : off;
        half_lane = big_endian ? {~off[OFF_W-1:1], 1'b0} : {off[OFF_W-1:1], 1'b0};
        case (size)
            SZ_BYTE: begin
                lane_en   = LANES'(1) << byte_lane;
                lane_data = byte_rep;
            end
            SZ_HALF: begin
                lane_en   = LANES'(3) << half_lane;
                lane_data = half_rep;
            end
            default: begin
                lane_en   = '1;
                lane_data = src;
            end
        endcase
    end
endmodule

// File: rtl/load_lane_extractor.sv
module load_lane_extractor
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        big_endian,
    input  xfer_size_e                  size,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic                        sgn,
    input  logic [DATA_W-1:0]           word,
    output logic [DATA_W-1:0]           result
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-1:0] half_lane;
    logic [7:0]       byte_sel;
    logic [15:0]      half_sel;

    always_comb begin
        byte_lane = big_endian ? ~off : off;
        half_lane = big_endian ? {~off[OFF_W-1:1], 1'b0} : {off[OFF_W-1:1], 1'b0};
        byte_sel  = word[8*byte_lane +: 8];
        half_sel  = word[8*half_lane +: 16];
        case (size)
            SZ_BYTE: result = {{(DATA_W-8){sgn & byte_sel[7]}}, byte_sel};
            SZ_HALF: result = {{(DATA_W-16){sgn & half_sel[15]}}, half_sel};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                big_endian_i,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [1:0]          req_size_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_signed_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic                mem_wen_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic                misaligned_o,
    input  logic                rsp_valid_i,
    input  logic [DATA_W-1:0]   rsp_data_i,
    output logic                ld_valid_o,
    output logic [DATA_W-1:0]   ld_data_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        xfer_size_e       size;
        logic [OFF_W-1:0] off;
        logic             sgn;
    } load_ctx_t;

    typedef struct packed {
        load_ctx_t         ctx;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
    } state_t;

    state_t st_d, st_q;

    xfer_size_e        req_size;
    logic [OFF_W-1:0]  req_off;
    logic              req_misaligned;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] ld_widened;
    logic              wen;

    assign req_size = xfer_size_e'(req_size_i);
    assign req_off  = req_addr_i[OFF_W-1:0];

    align_check #(.OFF_W(OFF_W)) u_check (
        .size       (req_size),
        .off        (req_off),
        .misaligned (req_misaligned)
    );

    store_lane_packer #(.DATA_W(DATA_W)) u_pack (
        .big_endian (big_endian_i),
        .size       (req_size),
        .off        (req_off),
        .src        (wr_data_i),
        .lane_en    (lane_en),
        .lane_data  (mem_wdata_o)
    );

    load_lane_extractor #(.DATA_W(DATA_W)) u_extract (
        .big_endian (big_endian_i),
        .size       (st_q.ctx.size),
        .off        (st_q.ctx.off),
        .sgn        (st_q.ctx.sgn),
        .word       (rsp_data_i),
        .result     (ld_widened)
    );

    assign wen          = req_valid_i & req_write_i & ~req_misaligned;
    assign mem_wen_o    = wen;
    assign mem_be_o     = wen ? lane_en : '0;
    assign misaligned_o = req_valid_i & req_misaligned;
    assign ld_valid_o   = st_q.ld_valid;
    assign ld_data_o    = st_q.ld_data;

    always_comb begin
        st_d = st_q;
        if (req_valid_i && !req_write_i && !req_misaligned) begin
            st_d.ctx.size = req_size;
            st_d.ctx.off  = req_off;
            st_d.ctx.sgn  = req_signed_i;
        end
        st_d.ld_valid = rsp_valid_i;
        if (rsp_valid_i) begin
            st_d.ld_data = ld_widened;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_o && req_size_i == SZ_BYTE) |-> $countones(mem_be_o) == 1);

    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_o && req_size_i == SZ_HALF) |-> $countones(mem_be_o) == 2);

    assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_o && req_size_i[1]) |-> mem_be_o == '1);

    assert_no_write_misaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned_o |-> (!mem_wen_o && mem_be_o == '0));

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_o && $past(st_q.ctx.size) == SZ_BYTE && !$past(st_q.ctx.sgn))
        |-> ld_data_o[DATA_W-1:8] == '0);

    assert_valid_follows_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |=> ld_valid_o);

    assert_valid_only_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_i |=> (!ld_valid_o && $stable(ld_data_o)));

    assert_load_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |-> !mem_wen_o);
endmodule

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        big_endian_i;
    logic        req_valid_i;
    logic        req_write_i;
    logic [1:0]  req_size_i;
    logic [31:0] req_addr_i;
    logic        req_signed_i;
    logic [31:0] wr_data_i;
    logic        mem_wen_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o;
    logic        misaligned_o;
    logic        rsp_valid_i;
    logic [31:0] rsp_data_i;
    logic        ld_valid_o;
    logic [31:0] ld_data_o;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lsu_lane_align uut (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_size_i(req_size_i), .req_addr_i(req_addr_i),
        .req_signed_i(req_signed_i), .wr_data_i(wr_data_i),
        .mem_wen_o(mem_wen_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
        .misaligned_o(misaligned_o), .rsp_valid_i(rsp_valid_i),
        .rsp_data_i(rsp_data_i), .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        req_valid_i = 0; req_write_i = 0; req_size_i = 0; req_addr_i = 0;
        req_signed_i = 0; wr_data_i = 0; rsp_valid_i = 0; rsp_data_i = 0;
    endtask

    task automatic drive_req(input bit wr, input logic [1:0] sz,
                             input logic [1:0] off, input bit sg, input logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1; req_write_i = wr; req_size_i = sz;
        req_addr_i = 32'h0000_4000 | {30'd0, off}; req_signed_i = sg; wr_data_i = d;
        #5;
    endtask

    task automatic run_load(input logic [1:0] sz, input logic [1:0] off, input bit sg,
                            input logic [31:0] mem, output logic [31:0] got, output logic vld);
        drive_req(0, sz, off, sg, 32'h0);
        @(negedge clk);
        req_valid_i = 0; rsp_valid_i = 1; rsp_data_i = mem;
        @(negedge clk);
        rsp_valid_i = 0; rsp_data_i = 32'hDEAD_BEEF;
        got = ld_data_o; vld = ld_valid_o;
    endtask

    function automatic logic [31:0] exp_byte(bit bend, logic [1:0] off, bit sg, logic [31:0] m);
        logic [1:0] lane = bend ? 2'd3 - off : off;
        logic [7:0] b = m[8*lane +: 8];
        return {{24{sg & b[7]}}, b};
    endfunction

    function automatic logic [31:0] exp_half(bit bend, logic [1:0] off, bit sg, logic [31:0] m);
        bit hi = bend ? ~off[1] : off[1];
        logic [15:0] h = hi ? m[31:16] : m[15:0];
        return {{16{sg & h[15]}}, h};
    endfunction

    task automatic t_reset();
        rst_n = 0; big_endian_i = 0; idle();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, ld_valid_o}, 32'd0);
        chk("R1 data in reset", ld_data_o, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, ld_valid_o}, 32'd0);
        chk("R1 data after reset", ld_data_o, 32'd0);
    endtask

    task automatic t_store_byte();
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            for (int o = 0; o < 4; o++) begin
                drive_req(1, 2'b00, o[1:0], 0, 32'hA5C3_7E5B);
                chk("R2 byte strobes", {28'd0, mem_be_o},
                    {28'd0, 4'b0001 << (e ? 3 - o : o)});
                chk("R2 byte data", mem_wdata_o, {4{8'h5B}});
                chk("R5 byte never misaligned", {31'd0, misaligned_o}, 32'd0);
                chk("R2 byte write enable", {31'd0, mem_wen_o}, 32'd1);
            end
        end
        idle();
    endtask

    task automatic t_store_half();
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            for (int o = 0; o < 4; o += 2) begin
                bit hi = e ? (o == 0) : (o == 2);
                drive_req(1, 2'b01, o[1:0], 0, 32'h1234_9ABC);
                chk("R3 half strobes", {28'd0, mem_be_o}, hi ? 32'hC : 32'h3);
                chk("R3 half data", mem_wdata_o, 32'h9ABC_9ABC);
                chk("R3 half write enable", {31'd0, mem_wen_o}, 32'd1);
            end
        end
        idle();
    endtask

    task automatic t_store_word();
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            for (int s = 2; s < 4; s++) begin
                drive_req(1, s[1:0], 2'b00, 0, 32'hCAFE_F00D);
                chk("R4 word strobes", {28'd0, mem_be_o}, 32'hF);
                chk("R4 word data", mem_wdata_o, 32'hCAFE_F00D);
            end
        end
        idle();
    endtask

    task automatic t_misaligned();
        big_endian_i = 0;
        for (int o = 1; o < 4; o += 2) begin
            drive_req(1, 2'b01, o[1:0], 0, 32'h1);
            chk("R5 half misaligned flag", {31'd0, misaligned_o}, 32'd1);
            chk("R5 half no write", {27'd0, mem_wen_o, mem_be_o}, 32'd0);
        end
        for (int o = 1; o < 4; o++) begin
            drive_req(1, 2'b10, o[1:0], 0, 32'h1);
            chk("R5 word misaligned flag", {31'd0, misaligned_o}, 32'd1);
            chk("R5 word no write", {27'd0, mem_wen_o, mem_be_o}, 32'd0);
        end
        drive_req(1, 2'b01, 2'b10, 0, 32'h1);
        chk("R5 aligned half not flagged", {31'd0, misaligned_o}, 32'd0);
        idle();
    endtask

    task automatic t_load_byte();
        logic [31:0] got; logic vld;
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            for (int o = 0; o < 4; o++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    run_load(2'b00, o[1:0], sg[0], 32'h8F_71_E2_53, got, vld);
                    chk("R10 byte load valid", {31'd0, vld}, 32'd1);
                    chk(sg ? "R7 byte sign fill" : "R6 byte zero fill", got,
                        exp_byte(e[0], o[1:0], sg[0], 32'h8F_71_E2_53));
                end
            end
        end
        idle();
    endtask

    task automatic t_load_half();
        logic [31:0] got; logic vld;
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            for (int o = 0; o < 4; o += 2) begin
                for (int sg = 0; sg < 2; sg++) begin
                    run_load(2'b01, o[1:0], sg[0], 32'h9234_7A5C, got, vld);
                    chk(sg ? "R7 half sign fill" : "R8 half select", got,
                        exp_half(e[0], o[1:0], sg[0], 32'h9234_7A5C));
                end
            end
        end
        idle();
    endtask

    task automatic t_load_word();
        logic [31:0] got; logic vld;
        for (int e = 0; e < 2; e++) begin
            big_endian_i = e[0];
            run_load(2'b10, 2'b00, 1'b1, 32'hF0E1_D2C3, got, vld);
            chk("R9 word unchanged", got, 32'hF0E1_D2C3);
        end
        idle();
    endtask

    task automatic t_valid_timing();
        logic [31:0] held;
        big_endian_i = 0;
        drive_req(0, 2'b10, 2'b00, 0, 32'h0);
        @(negedge clk);
        req_valid_i = 0;
        chk("R10 no valid before data", {31'd0, ld_valid_o}, 32'd0);
        rsp_valid_i = 1; rsp_data_i = 32'h0BAD_F00D;
        @(negedge clk);
        rsp_valid_i = 0; rsp_data_i = 32'h1111_2222;
        chk("R10 valid one cycle after data", {31'd0, ld_valid_o}, 32'd1);
        held = ld_data_o;
        chk("R10 registered data", held, 32'h0BAD_F00D);
        @(negedge clk);
        chk("R10 valid drops", {31'd0, ld_valid_o}, 32'd0);
        chk("R10 data held", ld_data_o, 32'h0BAD_F00D);
        idle();
    endtask

    task automatic t_misaligned_load_ctx();
        big_endian_i = 0;
        drive_req(0, 2'b00, 2'b01, 0, 32'h0);
        chk("R11 load no write", {31'd0, mem_wen_o}, 32'd0);
        drive_req(0, 2'b10, 2'b10, 1, 32'h0);
        chk("R11 misaligned load flagged", {31'd0, misaligned_o}, 32'd1);
        chk("R11 misaligned load no write", {31'd0, mem_wen_o}, 32'd0);
        @(negedge clk);
        req_valid_i = 0; rsp_valid_i = 1; rsp_data_i = 32'h44_33_C2_11;
        @(negedge clk);
        rsp_valid_i = 0;
        chk("R11 earlier context kept", ld_data_o, 32'h0000_00C2);
        idle();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_store_byte();
        t_store_half();
        t_store_word();
        t_misaligned();
        t_load_byte();
        t_load_half();
        t_load_word();
        t_valid_timing();
        t_misaligned_load_ctx();
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule